// File: doc/BRIEF.md
# Handshaked two-tap averaging filter

This block is a streaming low-pass filter of order one. Each sample arriving on its input port is averaged with the sample that came before it. The result, (x + y) / 2, is sent out on its output port. Both ports use four-phase request/acknowledge signalling, and the whole block runs on one clock. The environment drives the request and data inputs synchronously to that clock.

A new sample is captured when the input request is high, the input acknowledge is low and the output side is idle. Capture raises the input acknowledge, and from then on the producer may change the input data. The average is registered on the next clock, and the output request rises one clock after that. The history register takes the current sample only once the consumer has acknowledged the averaged result. The next sample is not taken until the whole output handshake has returned to zero.

Top module: `avg_filter`

## Requirements
- R1: After reset, ain_o and rout_o are low, data_o is zero and the history value is zero, so the first result equals the first sample halved.
- R2: Each result on data_o equals floor((x + y) / 2). Here x is the captured sample and y is the history value, and the sum is formed one bit wider than the sample so that it never overflows.
- R3: The history value becomes the current sample only after the consumer has acknowledged the result, so result n uses samples n and n-1.
- R4: The sample is captured on the clock edge at which ain_o rises. A change on data_i while ain_o is high has no effect on the result.
- R5: ain_o stays high while rin_i is high, and it falls one clock after rin_i is sampled low.
- R6: rout_o rises exactly two clocks after ain_o rises.
- R7: While rout_o is high and aout_i is low, rout_o stays high and data_o stays stable. rout_o falls one clock after aout_i is sampled high.
- R8: No new sample is captured (ain_o does not rise) while rout_o or aout_i is high.
- R9: rout_o stays low while aout_i is still high after rout_o has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rin_i | input | 1 | Input request; data_i is valid while it is high |
| ain_o | output | 1 | Input acknowledge; data_i may change once it is high |
| data_i | input | W | Input sample |
| rout_o | output | 1 | Output request; data_o is valid while it is high |
| aout_i | input | 1 | Output acknowledge |
| data_o | output | W | Averaged result, held in a register |

## Verification
The hardest situation to reach is a producer that raises a new request while the previous output handshake is still in progress. The filter must then hold ain_o low and keep the history value unchanged until aout_i has returned low. To get there, the bench runs the producer and the consumer as concurrent processes. The producer uses short random gaps, and the consumer holds the request open and delays its acknowledge return by random amounts. Directed samples at full scale, at zero and at odd values check the widened sum and the truncation. The producer also scrambles data_i as soon as ain_o rises.

// File: rtl/avg_filt_pkg.sv
package avg_filt_pkg;
  typedef enum logic [2:0] {
    OS_IDLE,
    OS_CALC,
    OS_ARM,
    OS_REQ,
    OS_RET
  } out_state_e;
endpackage

// File: rtl/avg_in_hs.sv
module avg_in_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rin_i,
  input  logic ready_i,
  output logic ain_o,
  output logic fire_o
);
  logic ain_q;

  assign fire_o = rin_i & ~ain_q & ready_i;
  assign ain_o  = ain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ain_q <= 1'b0;
    else if (fire_o)  ain_q <= 1'b1;
    else if (!rin_i)  ain_q <= 1'b0;
  end
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  input  logic         accept_i,
  output logic [W-1:0] data_o
);
  localparam int SW = W + 1;

  logic [W-1:0]  x_q, y_q, res_q;
  logic [SW-1:0] sum;

  // widened sum, halving by dropping the lsb
  assign sum    = {1'b0, x_q} + {1'b0, y_q};
  assign data_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      res_q <= '0;
    end else begin
      if (fire_i)   x_q   <= data_i;
      if (load_i)   res_q <= sum[SW-1:1];
      if (accept_i) y_q   <= x_q;
    end
  end
endmodule

// File: rtl/avg_out_hs.sv
module avg_out_hs
  import avg_filt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic aout_i,
  output logic ready_o,
  output logic load_o,
  output logic accept_o,
  output logic rout_o
);
  out_state_e state_q, state_d;

  assign ready_o  = (state_q == OS_IDLE) & ~aout_i;
  assign load_o   = (state_q == OS_CALC);
  assign accept_o = (state_q == OS_REQ) & aout_i;
  assign rout_o   = (state_q == OS_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OS_IDLE: if (fire_i)  state_d = OS_CALC;
      OS_CALC:              state_d = OS_ARM;
      OS_ARM:               state_d = OS_REQ;
      OS_REQ:  if (aout_i)  state_d = OS_RET;
      OS_RET:  if (!aout_i) state_d = OS_IDLE;
      default:              state_d = OS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/avg_filter.sv
module avg_filter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rin_i,
  output logic         ain_o,
  input  logic [W-1:0] data_i,
  output logic         rout_o,
  input  logic         aout_i,
  output logic [W-1:0] data_o
);
  logic fire, ready, load, accept;

  avg_in_hs in_hs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rin_i   (rin_i),
    .ready_i (ready),
    .ain_o   (ain_o),
    .fire_o  (fire)
  );

  avg_datapath #(.W(W)) dp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .data_i   (data_i),
    .load_i   (load),
    .accept_i (accept),
    .data_o   (data_o)
  );

  avg_out_hs out_hs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .aout_i   (aout_i),
    .ready_o  (ready),
    .load_o   (load),
    .accept_o (accept),
    .rout_o   (rout_o)
  );
endmodule

// File: rtl/avg_filter_chk.sv
module avg_filter_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rin_i,
  input logic         ain_o,
  input logic [W-1:0] data_i,
  input logic         rout_o,
  input logic         aout_i,
  input logic [W-1:0] data_o
);
  assert_ain_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ain_o && rin_i) |=> ain_o);

  assert_ain_return_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ain_o && !rin_i) |=> !ain_o);

  assert_rout_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ain_o) |-> ##2 $rose(rout_o));

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rout_o && !aout_i) |=> (rout_o && $stable(data_o)));

  assert_rout_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rout_o && aout_i) |=> !rout_o);

  assert_no_capture_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rout_o || aout_i) |=> !$rose(ain_o));

  assert_rout_return_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aout_i && !rout_o) |=> !rout_o);
endmodule

bind avg_filter avg_filter_chk #(.W(W)) chk_i (.*);

// File: tb/avg_filter_tb_top.sv
module avg_filter_tb_top;
  localparam int W = 8;
  localparam int N = 48;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, rin, ain, rout, aout;
  logic [W-1:0] din, dout;
  logic [W-1:0] vec [N];
  int n_chk = 0, n_fail = 0, cyc = 0, ain_rise_cyc = 0;
  bit done = 1'b0, mon_on = 1'b0;
  logic p_ain = 1'b0, p_rout = 1'b0, p_aout = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  avg_filter #(.W(W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .rin_i (rin), .ain_o (ain),
    .data_i (din), .rout_o (rout), .aout_i (aout), .data_o (dout)
  );

  function automatic logic [W-1:0] exp_avg(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W:1];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R8: a capture must never follow a cycle with the output busy
  always @(negedge clk) begin
    if (mon_on && ain && !p_ain)
      check(!p_rout && !p_aout, "R8 capture while output busy", {p_rout, p_aout}, 0);
    p_ain = ain; p_rout = rout; p_aout = aout;
  end

  task automatic produce(input int i);
    int gap, hold;
    gap = $urandom % 3;
    repeat (gap) @(negedge clk);
    din = vec[i];
    rin = 1'b1;
    do @(negedge clk); while (!ain);
    ain_rise_cyc = cyc;
    din = W'($urandom);          // R4: scrambled after capture
    hold = $urandom % 3;
    repeat (hold) begin
      @(negedge clk);
      check(ain == 1'b1, "R5 ain held while rin high", int'(ain), 1);
    end
    rin = 1'b0;
    @(negedge clk);
    check(ain == 1'b0, "R5 ain falls after rin low", int'(ain), 0);
  endtask

  task automatic consume(input int i);
    int hold, back;
    logic [W-1:0] e;
    do @(negedge clk); while (!rout);
    check(cyc - ain_rise_cyc == 2, "R6 rout delay", cyc - ain_rise_cyc, 2);
    e = exp_avg(vec[i], (i == 0) ? '0 : vec[i-1]);
    check(dout == e, (i == 0) ? "R1 R2 first result" : "R2 R3 R4 result", int'(dout), int'(e));
    hold = $urandom % 4;
    repeat (hold) begin
      @(negedge clk);
      check(rout && dout == e, "R7 output held", int'(dout), int'(e));
    end
    aout = 1'b1;
    @(negedge clk);
    check(rout == 1'b0, "R7 rout falls after aout", int'(rout), 0);
    back = $urandom % 3;
    repeat (back) begin
      @(negedge clk);
      check(rout == 1'b0, "R9 rout low until aout low", int'(rout), 0);
    end
    aout = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    vec[0] = W'(MAXV); vec[1] = W'(MAXV); vec[2] = '0; vec[3] = W'(1);
    vec[4] = '0;       vec[5] = W'(MAXV - 1); vec[6] = W'(1); vec[7] = W'(MAXV);
    for (int i = 8; i < N; i++) vec[i] = W'($urandom);
    rst_n = 1'b0; rin = 1'b0; aout = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    check(ain == 1'b0 && rout == 1'b0, "R1 reset handshake", {ain, rout}, 0);
    check(dout == '0, "R1 reset data", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    fork
      for (int i = 0; i < N; i++) produce(i);
      for (int i = 0; i < N; i++) consume(i);
    join
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule